// File: doc/BRIEF.md
# Late-Write Pipelined-Read SRAM Core

This block is a single-port synchronous memory. All of its controls are sampled on the rising clock edge: the address, an active-low select, an active-low write enable and one active-low enable per 9-bit byte lane. A read delivers its word through an output register one edge after the command edge. A write takes its data one edge after the command edge (late write). A deselect moves through the same two-stage output pipeline as a read. As a result, the data bus is released one full cycle after any cycle that is not a read.

An active-low output enable and a sleep input gate the output drive asynchronously. Sleep also blocks every operation without disturbing the stored words. A write whose data is still due when a read of the same word is issued is merged byte by byte into the read result, so reads always see the latest written value.

Top module: `lw_sram`

## Requirements
- R1: A read command is `selN`=0 and `wrN`=1 with `sleep`=0 at a rising edge. After the next rising edge, `doutEn` is 1 (given `oeN`=0) and `dout` holds the addressed word for one cycle.
- R2: A write command is `selN`=0 and `wrN`=0 with `sleep`=0 at a rising edge. The word is taken from `din` at the following rising edge. The value on `din` at the command edge is not stored.
- R3: `byteEnN` is sampled with the write command. Bit b low writes lane b, which is bits b*9+8 down to b*9. Any mix of lanes may be written, and other lanes keep their contents.
- R4: A write command with every `byteEnN` bit high is an abort and leaves the memory unchanged.
- R5: After a deselect (`selN`=1) or a write command at an edge, `doutEn` is 0 for the cycle after the next edge. `dout` reads all zeros whenever `doutEn` is 0.
- R6: While `oeN` is 1, `doutEn` is 0 in the same cycle, whatever the pipeline holds.
- R7: While `sleep` is 1, commands are ignored, outputs are off, and a write whose data falls due on a sleep edge is discarded. Stored words are kept.
- R8: A read of a word whose late-write data is taken on the read's command edge returns the new bytes for the enabled lanes and the stored bytes for the others.
- R9: Back-to-back writes each take their data on the edge after their own command, so a new command and the previous command's data share one cycle.
- R10: `rstN` low at an edge clears the command pipeline so that `doutEn` is 0. Memory contents survive the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low pipeline reset |
| addr | input | ADDR_W | Word address |
| selN | input | 1 | Active-low select |
| wrN | input | 1 | Active-low write enable |
| byteEnN | input | BYTES | Active-low lane write enables |
| din | input | BYTES*BYTE_W | Late write data |
| sleep | input | 1 | Power-down request, active high |
| oeN | input | 1 | Asynchronous active-low output enable |
| dout | output | BYTES*BYTE_W | Registered read data, zero when not driving |
| doutEn | output | 1 | Output drive indication |

## Verification
The timing properties assume that `selN`, `wrN` and `sleep` are steady around each rising edge. They also assume that a command two edges back is only meaningful when the pipeline was not under reset. The stimulus changes every input on the falling edge and starts reset checks only after the pipeline has drained. Coherence and lane merging rest on the memory holding known contents, so every word is written before the first read, using back-to-back late writes.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  // Strobes from control to datapath, one per pipeline action
  typedef struct packed {
    logic wrCap;   // latch address and lanes of a new write
    logic rdCap;   // sample array (with bypass) for a new read
    logic commit;  // late data arrives: update the array
    logic outLoad; // move read stage into the output register
  } lw_strb_t;
endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
  import lw_sram_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     selN,
  input  logic     wrN,
  input  logic     sleep,
  output lw_strb_t strb,
  output logic     outValid
);
  logic cmdRd, cmdWr;
  logic pendValid, rdValid;

  assign cmdRd = !selN &&  wrN && !sleep;
  assign cmdWr = !selN && !wrN && !sleep;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      rdValid   <= 1'b0;
      outValid  <= 1'b0;
    end else begin
      pendValid <= cmdWr;
      rdValid   <= cmdRd;
      outValid  <= rdValid && !sleep;
    end
  end

  always_comb begin
    strb.wrCap   = cmdWr;
    strb.rdCap   = cmdRd;
    strb.commit  = pendValid && !sleep;
    strb.outLoad = rdValid && !sleep;
  end
endmodule

// File: rtl/lw_sram_dpath.sv
module lw_sram_dpath
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  lw_strb_t                strb,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES-1:0]        byteEnN,
  input  logic [BYTES*BYTE_W-1:0] din,
  output logic [BYTES*BYTE_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] pendAddr;
  logic [BYTES-1:0]  pendLanes;
  logic              addrMatch;

  always_ff @(posedge clk) begin
    if (strb.wrCap) begin
      pendAddr  <= addr;
      pendLanes <= ~byteEnN;
    end
  end

  assign addrMatch = strb.commit && (pendAddr == addr);

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] memLane [DEPTH];
    logic [BYTE_W-1:0] dinLane, rdLane, qLane;
    logic              bypass;

    assign dinLane = din[b*BYTE_W +: BYTE_W];
    assign bypass  = addrMatch && pendLanes[b];

    always_ff @(posedge clk) begin
      if (strb.commit && pendLanes[b]) memLane[pendAddr] <= dinLane;
      if (strb.rdCap)   rdLane <= bypass ? dinLane : memLane[addr];
      if (strb.outLoad) qLane  <= rdLane;
    end

    assign q[b*BYTE_W +: BYTE_W] = qLane;
  end
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    selN,
  input  logic                    wrN,
  input  logic [BYTES-1:0]        byteEnN,
  input  logic [BYTES*BYTE_W-1:0] din,
  input  logic                    sleep,
  input  logic                    oeN,
  output logic [BYTES*BYTE_W-1:0] dout,
  output logic                    doutEn
);
  localparam int DW = BYTES * BYTE_W;

  lw_strb_t      strb;
  logic          outValid;
  logic [DW-1:0] qReg;

  lw_sram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .wrN(wrN), .sleep(sleep),
    .strb(strb), .outValid(outValid)
  );

  lw_sram_dpath #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_dpath (
    .clk(clk), .strb(strb), .addr(addr), .byteEnN(byteEnN), .din(din), .q(qReg)
  );

  assign doutEn = outValid && !oeN && !sleep;
  assign dout   = doutEn ? qReg : '0;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk (
  input logic clk,
  input logic rstN,
  input logic selN,
  input logic wrN,
  input logic sleep,
  input logic oeN,
  input logic doutEn
);
  // R6
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !doutEn);

  // R7
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !doutEn);

  // R1
  read_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    doutEn |-> $past(!selN && wrN && !sleep, 2));

  // R5
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!selN && !wrN, 2) |-> !doutEn);

  // R5
  desel_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(selN, 2) |-> !doutEn);
endmodule

bind lw_sram lw_sram_chk u_chk (
  .clk(clk), .rstN(rstN), .selN(selN), .wrN(wrN),
  .sleep(sleep), .oeN(oeN), .doutEn(doutEn)
);

// File: tb/lw_sram_bench.sv
module lw_sram_bench;
  localparam int AW = 4;
  localparam int NB = 2;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN = 1'b0, selN = 1'b1, wrN = 1'b1, sleep = 1'b0, oeN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] byteEnN = '1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          doutEn;

  lw_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u_lw_sram (
    .clk(clk), .rstN(rstN), .addr(addr), .selN(selN), .wrN(wrN),
    .byteEnN(byteEnN), .din(din), .sleep(sleep), .oeN(oeN),
    .dout(dout), .doutEn(doutEn)
  );

  // Reference state, behavioural
  logic [DW-1:0] refMem [DEPTH];
  logic          mPend = 1'b0, mRd = 1'b0, mOut = 1'b0;
  logic [AW-1:0] mPendA;
  logic [NB-1:0] mPendLanes;
  logic [DW-1:0] mRdData, mQ;
  int nChk = 0, nFail = 0;

  function automatic logic [DW-1:0] pat(int k);
    logic [31:0] t;
    t = k * 9973 + 4111;
    return t[DW-1:0];
  endfunction

  task automatic chk(string tag, logic en, logic [DW-1:0] d,
                     logic expEn, logic [DW-1:0] expD);
    nChk++;
    if (en !== expEn || d !== expD) begin
      nFail++;
      $display("FAIL %s: doutEn=%b dout=%h expected doutEn=%b dout=%h",
               tag, en, d, expEn, expD);
    end
  endtask

  task automatic modelEdge();
    if (!rstN) begin
      mPend = 0; mRd = 0; mOut = 0;
    end else begin
      mOut = mRd && !sleep;
      if (mRd && !sleep) mQ = mRdData;
      if (mPend && !sleep)
        for (int b = 0; b < NB; b++)
          if (mPendLanes[b]) refMem[mPendA][b*BW +: BW] = din[b*BW +: BW];
      mRd = !selN && wrN && !sleep;
      if (mRd) mRdData = refMem[addr];
      mPend = !selN && !wrN && !sleep;
      mPendA = addr;
      mPendLanes = ~byteEnN;
    end
  endtask

  // compare against model, take the edge, land on the next falling edge
  task automatic tick();
    logic expEn;
    #1;
    expEn = mOut && !oeN && !sleep;
    chk(expEn ? "R1 model" : "R5 model", doutEn, dout, expEn, expEn ? mQ : '0);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic cmd(logic s, logic w, logic [AW-1:0] a, logic [NB-1:0] be,
                     logic [DW-1:0] d);
    selN = s; wrN = w; addr = a; byteEnN = be; din = d;
    tick();
  endtask

  task automatic litChk(string tag, logic expEn, logic [DW-1:0] expD);
    #1;
    chk(tag, doutEn, dout, expEn, expD);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R10 reset state
    cmd(1, 1, 0, '1, '0); cmd(1, 1, 0, '1, '0);
    litChk("R10 reset", 1'b0, '0);
    rstN = 1'b1;

    // R9 back-to-back writes fill the array; R2 data one edge late
    for (int i = 0; i <= DEPTH; i++)
      cmd(i == DEPTH, 0, i[AW-1:0], '0, (i == 0) ? '1 : pat(i - 1));
    cmd(1, 1, 0, '1, '0);

    // R1 read latency
    cmd(0, 1, 5, '1, '0);
    litChk("R1 not yet", 1'b0, '0);
    cmd(1, 1, 0, '1, '0);
    litChk("R1 read", 1'b1, pat(5));
    // R6 async output enable
    oeN = 1'b1; litChk("R6 oe high", 1'b0, '0);
    oeN = 1'b0; litChk("R6 oe low", 1'b1, pat(5));
    cmd(1, 1, 0, '1, '0);
    litChk("R5 deselect", 1'b0, '0);

    // R9 first and last words
    cmd(0, 1, 0, '1, '0); cmd(1, 1, 0, '1, '0);
    litChk("R9 word0", 1'b1, pat(0));
    cmd(0, 1, 15, '1, '0); cmd(1, 1, 0, '1, '0);
    litChk("R9 word15", 1'b1, pat(15));

    // R3 lane 0 only; R2 command-edge data ignored
    cmd(0, 0, 2, 2'b10, '1);
    cmd(1, 1, 0, '1, 18'h00055);
    litChk("R5 after write", 1'b0, '0);
    cmd(0, 1, 2, '1, '0); cmd(1, 1, 0, '1, '0);
    litChk("R3 lane0", 1'b1, {pat(2)[17:9], 9'h055});

    // R4 abort
    cmd(0, 0, 7, 2'b11, '0);
    cmd(1, 1, 0, '1, '0);
    cmd(0, 1, 7, '1, '0); cmd(1, 1, 0, '1, '0);
    litChk("R4 abort", 1'b1, pat(7));

    // R8 read right after write, lane 1 bypassed
    cmd(0, 0, 9, 2'b01, '0);
    cmd(0, 1, 9, '1, 18'h2AAAA);
    cmd(1, 1, 0, '1, '0);
    litChk("R8 merge", 1'b1, {9'h155, pat(9)[8:0]});

    // R7 sleep drops late data and blocks a read
    cmd(0, 0, 4, '0, '0);
    sleep = 1'b1;
    cmd(0, 1, 4, '1, 18'h12345);
    litChk("R7 sleep out", 1'b0, '0);
    cmd(0, 0, 4, '0, 18'h0F0F0);
    sleep = 1'b0;
    cmd(1, 1, 0, '1, 18'h1);
    cmd(0, 1, 4, '1, '0); cmd(1, 1, 0, '1, '0);
    litChk("R7 kept", 1'b1, pat(4));

    // R10 contents survive reset
    rstN = 1'b0;
    cmd(0, 1, 5, '1, '0);
    litChk("R10 in reset", 1'b0, '0);
    rstN = 1'b1;
    cmd(1, 1, 0, '1, '0); cmd(1, 1, 0, '1, '0);
    cmd(0, 1, 5, '1, '0); cmd(1, 1, 0, '1, '0);
    litChk("R10 retained", 1'b1, pat(5));

    // random mix compared to the model every cycle
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      sleep = (r < 5);
      oeN = ($urandom_range(0, 9) == 0);
      selN = ($urandom_range(0, 4) == 0);
      wrN = $urandom_range(0, 1);
      addr = AW'($urandom_range(0, DEPTH - 1));
      byteEnN = NB'($urandom_range(0, (1 << NB) - 1));
      din = DW'($urandom);
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule